// File: doc/BRIEF.md
# Multi-Master Region Access Guard

This block decides, in the same cycle as a bus request, whether a bus master may touch an address. It holds a small table of regions. Each region has an inclusive lower bound, an inclusive upper bound, one valid bit, and read/write/execute rights for each of three masters: core, debugger and DMA. Each of several slave-side access ports sends an address, a master number and an access kind. The port gets back either a grant or an error. The decision is purely combinational. When a port is refused, the block records the address, the master, the direction and the regions that denied the access, and holds that record until software clears it.

Software reaches the table through a simple word-addressed register port. Region 0 is special. It always spans the whole address space and always lets the debugger in. Its bounds cannot be rewritten, and a non-debug master that tries gets a register error. Writing any region's bounds or rights word invalidates that region. A separate alternate rights register per region changes rights without touching the valid bit.

Register map, by word address:
- `0x00` is control. Bit 0 is the global enable, and bit 16+p is the error flag of port p, cleared by writing 1.
- `0x02+2p` holds the captured address of port p.
- `0x03+2p` holds the captured attributes of port p.
- `0x40+4n` to `0x43+4n` hold region n: lower bound, upper bound, rights, and valid in bit 0.
- `0x80+n` is the alternate rights register of region n.

Top module: `mem_guard`

## Requirements
- R1: After reset the global enable is 1. Region 0 is valid with lower bound 0x00000000, upper bound 0xFFFFFFFF and rights 0x1FF. Every other region reads valid 0.
- R2: A request from the debugger (master 1) is always granted, whatever has been written to the registers.
- R3: A register write from a non-debug master to region 0's lower or upper bound word (0x40, 0x41) raises `reg_err` in that cycle, even with the global enable and region 0 valid both clear. Such a write changes nothing. A debugger write there is ignored without error.
- R4: A write to word 0, 1 or 2 of any region clears that region's valid bit. Word 3 bit 0 writes the valid bit.
- R5: A write to the alternate rights register of region n updates that region's rights and leaves its valid bit unchanged. In region 0, the debugger rights field is always forced to ones, both through the rights word and through the alternate register.
- R6: The rights word holds bit 3m+k for master m (0 core, 1 debugger, 2 DMA) and kind k (0 read, 1 write, 2 exec). When valid regions overlap, the access is granted if any matching valid region permits it.
- R7: A request that no matching valid region permits gets `acc_err` and no `acc_gnt`. Idle ports show neither.
- R8: Matching is inclusive at 32-byte granularity. The low 5 bits of a lower bound are read as zeros, and the low 5 bits of an upper bound are read as ones.
- R9: On the clock edge after an error on port p whose flag is clear, the flag (control bit 16+p) sets. The address is captured, and the attribute word is captured as follows:
  - [31:16] is a bitmap of the valid regions that matched but denied, with region n at bit 15-n.
  - [5:4] is the master.
  - [0] is 1 for a write.
- R10: While a port's flag is set, its captured address and attributes do not change.
- R11: Writing 1 to a flag clears it. Clearing the flag does not let a retried refused access pass; only granting rights does.
- R12: With the global enable clear, every request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_mid | input | 2 | master issuing the register write |
| reg_addr | input | 8 | register word address |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational) |
| reg_err | output | 1 | register write refused |
| acc_req | input | NPORT | access request per port |
| acc_addr | input | NPORT*32 | access address per port |
| acc_mid | input | NPORT*2 | master per port |
| acc_type | input | NPORT*2 | 0 read, 1 write, 2 exec |
| acc_gnt | output | NPORT | access granted |
| acc_err | output | NPORT | access refused |

## Verification
Some properties are checked on every cycle:
- the debugger is always granted;
- grant and error are exclusive and only appear on a request;
- a non-debug write to region 0's bounds is refused;
- a flag sets after an error;
- a port's record stays frozen while its flag is up.

The bench scenarios show the rest:
- which bit a denying region lands on;
- that bound writes invalidate while alternate writes do not;
- that overlaps resolve to a grant;
- the exact 32-byte edges;
- that a retried access keeps failing until rights change.

// File: rtl/mem_guard.sv
module mem_guard #(
  parameter int NRGN  = 8,
  parameter int NPORT = 2,
  parameter int AW    = 32,
  parameter int GRAN  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_mid,
  input  logic [7:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                reg_err,
  input  logic [NPORT-1:0]    acc_req,
  input  logic [NPORT*AW-1:0] acc_addr,
  input  logic [NPORT*2-1:0]  acc_mid,
  input  logic [NPORT*2-1:0]  acc_type,
  output logic [NPORT-1:0]    acc_gnt,
  output logic [NPORT-1:0]    acc_err
);
  localparam logic [1:0] M_DBG  = 2'd1;
  localparam logic [8:0] DBG_RW = 9'b000_111_000;
  localparam logic [8:0] ALL_RW = 9'h1FF;
  localparam int         HB     = AW - GRAN;

  logic [AW-1:0]   rg_lo [NRGN];
  logic [AW-1:0]   rg_hi [NRGN];
  logic [8:0]      rg_rw [NRGN];
  logic [NRGN-1:0] rg_vld;
  logic            en;
  logic [NPORT-1:0] eflag;
  logic [AW-1:0]   ed_addr [NPORT];
  logic [31:0]     ed_attr [NPORT];
  logic [15:0]     dmap [NPORT];

  wire d_sel   = reg_addr[7:6] == 2'b01;
  wire a_sel   = reg_addr[7:4] == 4'h8;
  wire bnd0_wr = reg_wr && d_sel && reg_addr[5:2] == 4'd0 && !reg_addr[1];

  assign reg_err = bnd0_wr && reg_mid != M_DBG;

  function automatic logic permit(logic [8:0] rw, logic [1:0] mid, logic [1:0] ty);
    if (mid == 2'd3 || ty == 2'd3) return 1'b0;
    return rw[int'(mid) * 3 + int'(ty)];
  endfunction

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    wire [AW-1:0] a  = acc_addr[p*AW +: AW];
    wire [1:0]    m  = acc_mid[p*2 +: 2];
    wire [1:0]    t  = acc_type[p*2 +: 2];
    logic         ok;
    logic [15:0]  dm;
    always_comb begin
      ok = !en || m == M_DBG;
      dm = '0;
      for (int n = 0; n < NRGN; n++) begin
        if (rg_vld[n] && a[AW-1:GRAN] >= rg_lo[n][AW-1:GRAN] &&
            a[AW-1:GRAN] <= rg_hi[n][AW-1:GRAN]) begin
          if (permit(rg_rw[n], m, t)) ok = 1'b1;
          else dm[15-n] = 1'b1;
        end
      end
    end
    assign dmap[p]    = dm;
    assign acc_gnt[p] = acc_req[p] && ok;
    assign acc_err[p] = acc_req[p] && !ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b1;
      rg_vld <= NRGN'(1);
      for (int n = 0; n < NRGN; n++) begin
        rg_lo[n] <= '0;
        rg_hi[n] <= (n == 0) ? '1 : '0;
        rg_rw[n] <= (n == 0) ? ALL_RW : '0;
      end
    end else if (reg_wr) begin
      if (reg_addr == 8'h00) en <= reg_wdata[0];
      for (int n = 0; n < NRGN; n++) begin
        if (d_sel && reg_addr[5:2] == 4'(n)) begin
          case (reg_addr[1:0])
            2'd0: if (n != 0) begin rg_lo[n] <= reg_wdata[AW-1:0]; rg_vld[n] <= 1'b0; end
            2'd1: if (n != 0) begin rg_hi[n] <= reg_wdata[AW-1:0]; rg_vld[n] <= 1'b0; end
            2'd2: begin
              rg_rw[n]  <= reg_wdata[8:0] | ((n == 0) ? DBG_RW : 9'h0);
              rg_vld[n] <= 1'b0;
            end
            default: rg_vld[n] <= reg_wdata[0];
          endcase
        end
        if (a_sel && reg_addr[3:0] == 4'(n))
          rg_rw[n] <= reg_wdata[8:0] | ((n == 0) ? DBG_RW : 9'h0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eflag <= '0;
      for (int p = 0; p < NPORT; p++) begin
        ed_addr[p] <= '0;
        ed_attr[p] <= '0;
      end
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (acc_err[p] && !eflag[p]) begin
          eflag[p]   <= 1'b1;
          ed_addr[p] <= acc_addr[p*AW +: AW];
          ed_attr[p] <= {dmap[p], 10'b0, acc_mid[p*2 +: 2], 3'b0, acc_type[p*2 +: 2] == 2'd1};
        end else if (reg_wr && reg_addr == 8'h00 && reg_wdata[16+p]) begin
          eflag[p] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 8'h00) reg_rdata = (32'(eflag) << 16) | 32'(en);
    for (int p = 0; p < NPORT; p++) begin
      if (reg_addr == 8'(2 + 2*p)) reg_rdata = 32'(ed_addr[p]);
      if (reg_addr == 8'(3 + 2*p)) reg_rdata = ed_attr[p];
    end
    for (int n = 0; n < NRGN; n++) begin
      if (d_sel && reg_addr[5:2] == 4'(n)) begin
        case (reg_addr[1:0])
          2'd0:    reg_rdata = 32'(rg_lo[n]);
          2'd1:    reg_rdata = 32'(rg_hi[n]);
          2'd2:    reg_rdata = 32'(rg_rw[n]);
          default: reg_rdata = 32'(rg_vld[n]);
        endcase
      end
      if (a_sel && reg_addr[3:0] == 4'(n)) reg_rdata = 32'(rg_rw[n]);
    end
  end
endmodule

module mem_guard_chk #(
  parameter int NPORT = 2,
  parameter int AW    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [1:0]         reg_mid,
  input logic [7:0]         reg_addr,
  input logic               reg_err,
  input logic [NPORT-1:0]   acc_req,
  input logic [NPORT*2-1:0] acc_mid,
  input logic [NPORT-1:0]   acc_gnt,
  input logic [NPORT-1:0]   acc_err,
  input logic [NPORT-1:0]   eflag,
  input logic [AW-1:0]      ed_addr [NPORT],
  input logic [31:0]        ed_attr [NPORT]
);
  a_r3_bound_lock: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_mid != 2'd1 && (reg_addr == 8'h40 || reg_addr == 8'h41) |-> reg_err);

  for (genvar p = 0; p < NPORT; p++) begin : g_p
    a_r2_dbg_pass: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req[p] && acc_mid[p*2 +: 2] == 2'd1 |-> acc_gnt[p]);
    a_r7_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req[p] |-> acc_gnt[p] != acc_err[p]);
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_req[p] |-> !acc_gnt[p] && !acc_err[p]);
    a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err[p] && !eflag[p] |=> eflag[p]);
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      eflag[p] |=> $stable(ed_addr[p]) && $stable(ed_attr[p]));
  end
endmodule

bind mem_guard mem_guard_chk #(.NPORT(NPORT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_mid(reg_mid),
  .reg_addr(reg_addr), .reg_err(reg_err), .acc_req(acc_req),
  .acc_mid(acc_mid), .acc_gnt(acc_gnt), .acc_err(acc_err),
  .eflag(eflag), .ed_addr(ed_addr), .ed_attr(ed_attr)
);

// File: tb/mem_guard_test.sv
module mem_guard_test;
  localparam int NP = 2;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_mid = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic reg_err;
  logic [NP-1:0] acc_req = 0, acc_gnt, acc_err;
  logic [NP*32-1:0] acc_addr = 0;
  logic [NP*2-1:0] acc_mid = 0, acc_type = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  mem_guard uut (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [1:0] m, output logic e);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_mid = m;
    #1 e = reg_err;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic wc(logic [7:0] a, logic [31:0] d);
    logic e;
    wr(a, d, 2'd0, e);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic acc(int p, logic [31:0] a, logic [1:0] m, logic [1:0] t, output logic g, output logic e);
    @(negedge clk);
    acc_addr[p*32 +: 32] = a; acc_mid[p*2 +: 2] = m; acc_type[p*2 +: 2] = t; acc_req[p] = 1;
    #1 g = acc_gnt[p]; e = acc_err[p];
    @(posedge clk); #1 acc_req[p] = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); chk("R1 ctrl", d, 32'h1);
    rd(8'h40, d); chk("R1 lo0", d, 32'h0);
    rd(8'h41, d); chk("R1 hi0", d, 32'hFFFFFFFF);
    rd(8'h42, d); chk("R1 rw0", d, 32'h1FF);
    rd(8'h43, d); chk("R1 vld0", d, 32'h1);
    rd(8'h47, d); chk("R1 vld1", d, 32'h0);
  endtask

  task automatic t_lock;
    logic e; logic [31:0] d;
    wc(8'h00, 32'h0); wc(8'h43, 32'h0);
    wr(8'h40, 32'h1234, 2'd0, e); chk("R3 core lo err", e, 1);
    rd(8'h40, d); chk("R3 lo kept", d, 0);
    wr(8'h41, 32'h100, 2'd2, e); chk("R3 dma hi err", e, 1);
    wr(8'h41, 32'h100, 2'd1, e); chk("R3 dbg no err", e, 0);
    rd(8'h41, d); chk("R3 hi kept", d, 32'hFFFFFFFF);
    wc(8'h00, 32'h1); wc(8'h43, 32'h1);
  endtask

  task automatic t_invalidate;
    logic [31:0] d;
    for (int w = 0; w < 3; w++) begin
      wc(8'h47, 1);
      wc(8'h44 + 8'(w), 32'h40);
      rd(8'h47, d); chk("R4 word write clears valid", d, 0);
    end
    wc(8'h42, 32'h001);
    rd(8'h43, d); chk("R4 rgn0 rights clears valid", d, 0);
    rd(8'h42, d); chk("R5 dbg forced via word", d, 32'h039);
    wc(8'h43, 1);
  endtask

  task automatic t_alt;
    logic [31:0] d;
    wc(8'h47, 1);
    wc(8'h81, 32'h7);
    rd(8'h47, d); chk("R5 alt keeps valid", d, 1);
    rd(8'h46, d); chk("R5 alt rights", d, 7);
    wc(8'h80, 32'h0);
    rd(8'h42, d); chk("R5 dbg forced via alt", d, 32'h038);
    rd(8'h43, d); chk("R5 rgn0 valid kept", d, 1);
  endtask

  task automatic t_debugger;
    logic g, e;
    acc(0, 32'h0500, 2'd0, 2'd0, g, e); chk("R7 core denied", e, 1);
    acc(0, 32'h12345678, 2'd1, 2'd1, g, e); chk("R2 dbg write", g, 1);
    acc(1, 32'hFFFFFFE0, 2'd1, 2'd2, g, e); chk("R2 dbg exec", g, 1);
  endtask

  task automatic t_overlap;
    logic g, e;
    wc(8'h44, 32'h1000); wc(8'h45, 32'h1FFF); wc(8'h46, 32'h001); wc(8'h47, 1);
    wc(8'h48, 32'h1800); wc(8'h49, 32'h27FF); wc(8'h4A, 32'h002); wc(8'h4B, 1);
    acc(0, 32'h1900, 2'd0, 2'd0, g, e); chk("R6 read overlap", g, 1);
    acc(0, 32'h1900, 2'd0, 2'd1, g, e); chk("R6 write overlap", g, 1);
    acc(0, 32'h1100, 2'd0, 2'd1, g, e); chk("R7 write no permit", e, 1);
    acc(0, 32'h1900, 2'd0, 2'd2, g, e); chk("R7 exec no permit", e, 1);
  endtask

  task automatic t_bounds;
    logic g, e;
    wc(8'h44, 32'h101F); wc(8'h45, 32'h1FE0); wc(8'h47, 1);
    acc(0, 32'h1000, 2'd0, 2'd0, g, e); chk("R8 low edge", g, 1);
    acc(0, 32'h1FFF, 2'd0, 2'd0, g, e); chk("R8 high edge", g, 1);
    acc(0, 32'h0FFF, 2'd0, 2'd0, g, e); chk("R8 below", e, 1);
    acc(0, 32'h2000, 2'd0, 2'd0, g, e); chk("R8 above", e, 1);
  endtask

  task automatic t_capture;
    logic g, e; logic [31:0] d;
    wc(8'h00, 32'h00030001);
    rd(8'h00, d); chk("R11 both cleared", d, 32'h1);
    acc(1, 32'h1100, 2'd2, 2'd1, g, e); chk("R7 dma err", e, 1);
    rd(8'h00, d); chk("R9 flag1", d, 32'h00020001);
    rd(8'h04, d); chk("R9 addr", d, 32'h1100);
    rd(8'h05, d); chk("R9 attr", d, 32'hC0000021);
    acc(1, 32'h0500, 2'd0, 2'd0, g, e);
    rd(8'h04, d); chk("R10 addr frozen", d, 32'h1100);
    rd(8'h05, d); chk("R10 attr frozen", d, 32'hC0000021);
  endtask

  task automatic t_retry;
    logic g, e; logic [31:0] d;
    wc(8'h00, 32'h00020001);
    rd(8'h00, d); chk("R11 flag cleared", d, 32'h1);
    acc(1, 32'h1100, 2'd2, 2'd1, g, e); chk("R11 retry still err", e, 1);
    rd(8'h00, d); chk("R11 flag again", d, 32'h00020001);
    wc(8'h81, 32'h081);
    acc(1, 32'h1100, 2'd2, 2'd1, g, e); chk("R11 granted after rights", g, 1);
  endtask

  task automatic t_disable;
    logic g, e;
    wc(8'h00, 32'h0);
    acc(0, 32'h0, 2'd0, 2'd2, g, e); chk("R12 disabled grant", g, 1);
    acc(1, 32'h0, 2'd2, 2'd0, g, e); chk("R12 disabled dma", g, 1);
    wc(8'h00, 32'h1);
    acc(0, 32'h0, 2'd0, 2'd2, g, e); chk("R12 enabled deny", e, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset; t_lock; t_invalidate; t_alt; t_debugger;
    t_overlap; t_bounds; t_capture; t_retry; t_disable;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule